// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase lines of an incremental rotary or linear encoder into a running position. It runs on one system clock. On every rising edge it samples the 2-bit phase input and compares it with the value it held at the previous edge. A single forward Gray step moves the position up by one. A single backward step moves it down by one. No change leaves the position as it is. When both bits flip at once, the step cannot be decoded, so the position is left unchanged.

Two 8-bit views of one internal position register are presented. The fine view counts every transition. The coarse view counts one per full four-transition encoder cycle, which is one mechanical line of the encoder. Both views are plain slices of the same register, so they always agree. Both wrap freely in either direction. The phase lines are expected to have been synchronised and filtered upstream. The phase sampled at an edge is already reflected on both outputs just after that edge.

Top module: `qenc_counter`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears the position to zero and loads 00 as the remembered phase. Both outputs then read 0, so a first sampled phase of 01 after reset counts as one forward step.
- R2: Forward order of the phase input is 00 → 01 → 11 → 10 → 00. When the phase sampled at an edge is the forward successor of the one sampled at the previous edge, `count_full` reads one more (mod 256) right after that same edge.
- R3: When the sampled phase is the backward neighbour of the previous one (the reverse of the R2 order), `count_full` reads one less (mod 256) right after that edge.
- R4: When the sampled phase equals the previous one, both outputs keep their values.
- R5: A jump where both bits change (00↔11 or 01↔10) leaves both outputs unchanged. The jumped-to value becomes the remembered phase, so the next step is decoded relative to it.
- R6: `count_div` equals bits [9:2] of a 10-bit position whose low 8 bits are `count_full`. It therefore advances once per four transitions, on the step where `count_full[1:0]` goes from 3 to 0, and it falls back on the step from 0 to 3.
- R7: `count_full` wraps from 255 to 0 going forward and from 0 to 255 going backward, with no saturation.
- R8: `count_div` wraps the same way, consistent with the full count. A backward step from position 0 gives `count_full` = 255 and `count_div` = 255, and the position wraps at 1024.
- R9: A long sequence of single steps, holds and reversals in any mix keeps both outputs exactly equal to the true position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the phase input is sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| phase_in | input | 2 | Encoder phase lines, already synchronised, Gray coded |
| count_full | output | 8 | Position at full resolution, one count per transition |
| count_div | output | 8 | Position divided by four, one count per encoder cycle |

## Verification
The bench goes after the edges of the counting range. A backward step straight out of reset must give 255 on both outputs; a design that kept the coarse count in a separate 8-bit register, or that saturated, would show 0 or a coarse value out of step with the fine one. A double-bit jump is followed at once by a normal step. This catches a design that counts the jump, and also one that fails to remember the jumped-to phase, because that design would then decode the next step in the wrong direction. Reset is released with the phase already at 01. A design that does not clear its remembered phase to 00, or that adds a pipeline stage before the count, would be one count off, or one edge late, at the very first sample.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    // Two encoder phase lines, Gray coded.
    typedef logic [1:0] phase_t;

    // Difference of the decoded phases, modulo 4, named by meaning.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_BAD  = 2'd2,
        STEP_DOWN = 2'd3
    } step_kind_e;

    // Command handed from the phase tracker to the accumulator.
    typedef struct packed {
        logic move;   // position changes this edge
        logic down;   // direction when move is set
    } step_cmd_t;

    // Gray phase to 2-bit binary index within an encoder cycle.
    function automatic logic [1:0] phase_to_index(input phase_t g);
        return {g[1], g[1] ^ g[0]};
    endfunction

    // Classify a transition between two sampled phases.
    function automatic step_kind_e classify_step(input phase_t prev_ph,
                                                 input phase_t cur_ph);
        logic [1:0] delta;
        delta = phase_to_index(cur_ph) - phase_to_index(prev_ph);
        return step_kind_e'(delta);
    endfunction

    // Turn a classified transition into an accumulator command.
    function automatic step_cmd_t to_command(input step_kind_e kind);
        step_cmd_t cmd;
        cmd.move = (kind == STEP_UP) || (kind == STEP_DOWN);
        cmd.down = (kind == STEP_DOWN);
        return cmd;
    endfunction

endpackage

// File: rtl/qenc_phase_tracker.sv
module qenc_phase_tracker
    import qenc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  phase_t    phase_in,
    output step_cmd_t step_cmd
);

    phase_t     last_phase;
    step_kind_e kind;

    // The remembered phase always follows the input, even across a jump,
    // so that decoding resumes relative to the value last seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_phase <= 2'b00;
        end else begin
            last_phase <= phase_in;
        end
    end

    // Decode from the registered previous phase and the live input so that
    // the accumulator can act on the very edge that samples the new phase.
    always_comb begin
        kind     = classify_step(last_phase, phase_in);
        step_cmd = to_command(kind);
    end

endmodule

// File: rtl/qenc_position_accum.sv
module qenc_position_accum
    import qenc_pkg::*;
#(
    parameter int POS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_cmd_t        step_cmd,
    output logic [POS_W-1:0] position
);

    localparam logic [POS_W-1:0] ONE = POS_W'(1);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_d;

    always_comb begin
        pos_d = pos_q;
        if (step_cmd.move) begin
            if (step_cmd.down) begin
                pos_d = pos_q - ONE;
            end else begin
                pos_d = pos_q + ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign position = pos_q;

endmodule

// File: rtl/qenc_output_tap.sv
module qenc_output_tap #(
    parameter int POS_W     = 10,
    parameter int OUT_W     = 8,
    parameter int DIV_SHIFT = 2
) (
    input  logic [POS_W-1:0] position,
    output logic [OUT_W-1:0] fine_out,
    output logic [OUT_W-1:0] coarse_out
);

    localparam int COARSE_TOP = OUT_W + DIV_SHIFT;

    // Both views are slices of one register, so they cannot drift apart.
    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        assign fine_out[i] = position[i];
        if (i + DIV_SHIFT < POS_W) begin : g_have
            assign coarse_out[i] = position[i + DIV_SHIFT];
        end else begin : g_pad
            assign coarse_out[i] = 1'b0;
        end
    end

    initial begin
        if (POS_W < COARSE_TOP) begin
            $error("position register narrower than the coarse view needs");
        end
    end

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int OUT_W     = 8,
    parameter int DIV_SHIFT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       phase_in,
    output logic [OUT_W-1:0] count_full,
    output logic [OUT_W-1:0] count_div
);

    localparam int POS_W = OUT_W + DIV_SHIFT;

    step_cmd_t        step_cmd;
    logic [POS_W-1:0] position;

    qenc_phase_tracker u_tracker (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_in (phase_in),
        .step_cmd (step_cmd)
    );

    qenc_position_accum #(
        .POS_W (POS_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_cmd (step_cmd),
        .position (position)
    );

    qenc_output_tap #(
        .POS_W     (POS_W),
        .OUT_W     (OUT_W),
        .DIV_SHIFT (DIV_SHIFT)
    ) u_tap (
        .position   (position),
        .fine_out   (count_full),
        .coarse_out (count_div)
    );

endmodule

// File: rtl/qenc_counter_chk.sv
module qenc_counter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] phase_in,
    input logic [7:0] count_full,
    input logic [7:0] count_div
);

    function automatic logic fwd_pair(input logic [1:0] a, input logic [1:0] b);
        return (a == 2'b00 && b == 2'b01) || (a == 2'b01 && b == 2'b11) ||
               (a == 2'b11 && b == 2'b10) || (a == 2'b10 && b == 2'b00);
    endfunction

    function automatic logic jump_pair(input logic [1:0] a, input logic [1:0] b);
        return (a ^ b) == 2'b11;
    endfunction

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (count_full == 8'd0 && count_div == 8'd0));

    // R2
    fwd_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) &&
         fwd_pair($past(phase_in, 2), $past(phase_in)))
        |-> count_full == $past(count_full) + 8'd1);

    // R3
    rev_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) &&
         fwd_pair($past(phase_in), $past(phase_in, 2)))
        |-> count_full == $past(count_full) - 8'd1);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) &&
         $past(phase_in, 2) == $past(phase_in))
        |-> ($stable(count_full) && $stable(count_div)));

    // R5
    jump_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) &&
         jump_pair($past(phase_in, 2), $past(phase_in)))
        |-> ($stable(count_full) && $stable(count_div)));

    // R6
    div_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_div[5:0] == count_full[7:2]);

    // R6
    div_moves_on_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(count_div))
        |-> (count_full[1:0] == 2'd0 && $past(count_full[1:0]) == 2'd3) ||
            (count_full[1:0] == 2'd3 && $past(count_full[1:0]) == 2'd0));

endmodule

bind qenc_counter qenc_counter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_in   (phase_in),
    .count_full (count_full),
    .count_div  (count_div)
);

// File: tb/qenc_counter_tb.sv
module qenc_counter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] phase_in = 2'b00;
    logic [7:0] count_full;
    logic [7:0] count_div;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [9:0] mpos;    // true position
    logic [1:0] mphase;  // phase currently driven

    always #4 clk = ~clk;   // 125 MHz

    qenc_counter u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_in   (phase_in),
        .count_full (count_full),
        .count_div  (count_div)
    );

    function automatic logic [1:0] g2b(input logic [1:0] g);
        return {g[1], g[1] ^ g[0]};
    endfunction

    function automatic logic [1:0] b2g(input logic [1:0] b);
        return {b[1], b[1] ^ b[0]};
    endfunction

    task automatic check(input string tag);
        checks++;
        if (count_full !== mpos[7:0] || count_div !== mpos[9:2]) begin
            fails++;
            $display("FAIL %s: full=%0d div=%0d expected full=%0d div=%0d",
                     tag, count_full, count_div, mpos[7:0], mpos[9:2]);
        end
    endtask

    task automatic check_val(input string tag, input logic [7:0] ef,
                             input logic [7:0] ed);
        checks++;
        if (count_full !== ef || count_div !== ed) begin
            fails++;
            $display("FAIL %s: full=%0d div=%0d expected full=%0d div=%0d",
                     tag, count_full, count_div, ef, ed);
        end
    endtask

    // Drive at a falling edge, wait over one rising edge, sample at the next fall.
    task automatic apply(input logic [1:0] ph);
        phase_in = ph;
        @(negedge clk);
    endtask

    task automatic move(input bit up, input string tag);
        logic [1:0] b;
        b = g2b(mphase);
        b = up ? b + 2'd1 : b - 2'd1;
        mphase = b2g(b);
        mpos   = up ? mpos + 10'd1 : mpos - 10'd1;
        apply(mphase);
        check(tag);
    endtask

    task automatic hold(input string tag);
        apply(mphase);
        check(tag);
    endtask

    task automatic jump(input string tag);
        mphase = mphase ^ 2'b11;
        apply(mphase);
        check(tag);
    endtask

    task automatic do_reset(input logic [1:0] ph_during);
        @(negedge clk);
        rst_n = 1'b0;
        phase_in = ph_during;
        repeat (3) @(negedge clk);
        mpos = '0;
        mphase = 2'b00;
        check("R1 reset");
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int r;
        void'($urandom(32'd20250611));
        mpos = '0;
        mphase = 2'b00;
        repeat (2) @(negedge clk);

        // R1 reset state, then first sample 00 holds at zero.
        do_reset(2'b00);
        hold("R1 hold after reset");

        // R2 forward steps across several cycles; R6 coarse count.
        for (int i = 0; i < 12; i++) move(1'b1, "R2 forward");
        check_val("R6 twelve steps", 8'd12, 8'd3);

        // R3 reverse steps, with direction changes.
        for (int i = 0; i < 5; i++) move(1'b0, "R3 reverse");
        move(1'b1, "R3 reversal up");
        move(1'b0, "R3 reversal down");

        // R4 holds.
        for (int i = 0; i < 4; i++) hold("R4 hold");

        // R5 jump both ways, then a step relative to the new phase.
        jump("R5 jump");
        move(1'b1, "R5 step after jump");
        jump("R5 jump back");
        move(1'b0, "R5 step after second jump");

        // R7/R8 backward wrap straight out of reset.
        do_reset(2'b00);
        move(1'b0, "R7 wrap down");
        check_val("R8 wrap down", 8'd255, 8'd255);
        move(1'b1, "R7 wrap up");
        check_val("R8 wrap up", 8'd0, 8'd0);

        // R1 remembered phase is 00: reset released with phase 01 counts one.
        do_reset(2'b01);
        mphase = 2'b01;
        mpos = 10'd1;
        apply(2'b01);
        check("R1 first sample 01");

        // R7/R8 full forward lap of the 10-bit position.
        for (int i = 0; i < 1100; i++) move(1'b1, "R8 forward lap");

        // R9 random mix.
        for (int i = 0; i < 6000; i++) begin
            r = int'($urandom_range(0, 99));
            if (r < 44)      move(1'b1, "R9 random up");
            else if (r < 88) move(1'b0, "R9 random down");
            else if (r < 96) hold("R9 random hold");
            else             jump("R9 random jump");
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule